// File: doc/BRIEF.md
# Serial Bus Master Frame Header Generator

This block is the master-side header source for a single-wire, LIN-style serial bus. When the host pulses a start request together with a 6-bit message identifier, the block drives the header onto its transmit line. The header is a long low break, a short high delimiter, a UART-framed 0x55 timing byte and a UART-framed identifier byte. Slaves use the timing byte to lock onto the master's bit rate. The identifier byte carries two parity bits that the block computes itself.

Only the master starts a frame, so this block is the single source of headers on the bus. The host sets the bit period through a divisor input. It sets the break length (13 to 16 bit times) and the delimiter length (1 to 4 bit times) through two small code inputs. A busy output covers the whole header. A one-cycle completion pulse marks the point at which a response phase may begin. The bit period is never shorter than the one that matches the bus's maximum rate, whatever divisor is requested.

Top module: `lin_hdr_gen`

## Requirements
- R1: After reset `tx_o`=1, `busy_o`=0 and `done_o`=0, and `tx_o` is 1 in every cycle in which `busy_o` is 0.
- R2: The header opens with 13+`brk_len_i` bit times of 0 on `tx_o`.
- R3: The break is followed by 1+`dlm_len_i` bit times of 1.
- R4: Next come ten bit times: a 0 start bit, the byte 0x55 sent least significant bit first (1,0,1,0,1,0,1,0), and a 1 stop bit.
- R5: Last come ten bit times: a 0 start bit, identifier bits 0 to 5 least significant first, then P0 = id0^id1^id2^id4, then P1 = NOT(id1^id3^id4^id5), then a 1 stop bit.
- R6: One bit time is `div_i`+1 clock cycles. `div_i`, `id_i`, `brk_len_i` and `dlm_len_i` are captured when a start is accepted, and changing them while busy has no effect on the header in progress.
- R7: One bit time is never shorter than CLK_HZ/MAX_BPS cycles. A smaller requested period is raised to that floor.
- R8: A start is accepted when `start_i`=1 and `busy_o`=0. `busy_o` is 1 from the next cycle for exactly (header bit times × bit period) cycles.
- R9: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R10: A `start_i` pulse while `busy_o`=1 is ignored. The header in progress continues unchanged and no further header follows.
- R11: A start request in the cycle where `done_o`=1 is accepted, so headers can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Header start request |
| id_i | input | 6 | Message identifier |
| div_i | input | DIV_W | Bit period minus one, in clock cycles |
| brk_len_i | input | 2 | Break length code (13 + code bit times) |
| dlm_len_i | input | 2 | Delimiter length code (1 + code bit times) |
| tx_o | output | 1 | Serial transmit line, idles high |
| busy_o | output | 1 | Header in progress |
| done_o | output | 1 | One-cycle header completion pulse |

## Verification
A completion pulse and a fresh start request can fall in the same cycle: busy has just dropped and the host launches the next header at once. The bench provokes this by waiting for the cycle in which `done_o` is high and raising `start_i` in that same cycle. It then expects `busy_o` high in the very next cycle and a second complete header, checked bit by bit by the scoreboard. The opposite collision, a start request landing mid-header, is also driven. The bench judges it by the unchanged bit stream and by the absence of a further header afterwards.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int SLOT_W      = 6;
  localparam int BRK_MIN     = 13;
  localparam int DLM_MIN     = 1;
  localparam int FRAME_SLOTS = 10;
  localparam logic [7:0] SYNC_BYTE = 8'h55;

  // identifier plus its two protection bits, bit 0 sent first
  function automatic logic [7:0] id_field(logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  // number of bit slots in one header
  function automatic logic [SLOT_W-1:0] hdr_slots(logic [1:0] b, logic [1:0] d);
    return SLOT_W'(BRK_MIN + DLM_MIN + 2*FRAME_SLOTS + int'(b) + int'(d));
  endfunction

  // line level in bit slot k of a header
  function automatic logic hdr_bit(logic [SLOT_W-1:0] k, logic [1:0] b,
                                   logic [1:0] d, logic [5:0] id);
    int kk, nb, nd, j;
    logic [7:0] byte_v;
    kk = int'(k);
    nb = BRK_MIN + int'(b);
    nd = DLM_MIN + int'(d);
    if (kk < nb) return 1'b0;
    if (kk < nb + nd) return 1'b1;
    j = kk - nb - nd;
    byte_v = SYNC_BYTE;
    if (j >= FRAME_SLOTS) begin
      j = j - FRAME_SLOTS;
      byte_v = id_field(id);
    end
    if (j == 0) return 1'b0;
    if (j >= FRAME_SLOTS - 1) return 1'b1;
    return byte_v[3'(j - 1)];
  endfunction
endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [5:0]        id_i,
  input  logic [1:0]        brk_i,
  input  logic [1:0]        dlm_i,
  input  logic [DIV_W-1:0]  lim_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [5:0]        id_o,
  output logic [1:0]        brk_o,
  output logic [1:0]        dlm_o,
  output logic [DIV_W-1:0]  lim_o
);
  logic accept, last_slot;

  assign accept    = start_i && !busy_o;
  assign last_slot = (slot_o == hdr_slots(brk_o, dlm_o) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      slot_o <= '0;
      id_o   <= '0;
      brk_o  <= '0;
      dlm_o  <= '0;
      lim_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o <= 1'b1;
        slot_o <= '0;
        id_o   <= id_i;
        brk_o  <= brk_i;
        dlm_o  <= dlm_i;
        lim_o  <= lim_i;
      end else if (busy_o && tick_i) begin
        if (last_slot) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          slot_o <= slot_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
  import lin_hdr_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int CLK_HZ  = 100_000_000,
  parameter int MAX_BPS = 20_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [5:0]       id_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       brk_len_i,
  input  logic [1:0]       dlm_len_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int               MIN_PERIOD = CLK_HZ / MAX_BPS;
  localparam logic [DIV_W-1:0] MIN_LIM    = DIV_W'(MIN_PERIOD - 1);

  logic [DIV_W-1:0]  lim_req, lim_q;
  logic              slot_tick;
  logic [SLOT_W-1:0] slot_idx;
  logic [5:0]        id_q;
  logic [1:0]        brk_q, dlm_q;

  // enforce the bus's maximum bit rate
  assign lim_req = (div_i < MIN_LIM) ? MIN_LIM : div_i;

  lin_hdr_seq #(.DIV_W(DIV_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_i(id_i),
    .brk_i(brk_len_i), .dlm_i(dlm_len_i), .lim_i(lim_req),
    .tick_i(slot_tick), .busy_o(busy_o), .done_o(done_o),
    .slot_o(slot_idx), .id_o(id_q), .brk_o(brk_q), .dlm_o(dlm_q),
    .lim_o(lim_q)
  );

  lin_bit_timer #(.DIV_W(DIV_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(busy_o), .lim_i(lim_q),
    .tick_o(slot_tick)
  );

  assign tx_o = busy_o ? hdr_bit(slot_idx, brk_q, dlm_q, id_q) : 1'b1;
endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk #(
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          tx_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          slot_tick,
  input logic [SW-1:0] slot_idx
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
  a_r2_break_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !tx_o);
  a_r6_tx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(tx_o)) |-> $past(slot_tick));
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (slot_idx >= $past(slot_idx)));
endmodule

bind lin_hdr_gen lin_hdr_chk #(.SW(lin_hdr_pkg::SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_o(tx_o),
  .busy_o(busy_o), .done_o(done_o), .slot_tick(slot_tick),
  .slot_idx(slot_idx)
);

// File: tb/lin_hdr_gen_tb_top.sv
`timescale 1ns/1ps
module lin_hdr_gen_tb_top;
  localparam int DIV_W = 16;
  localparam int MINP  = 8;   // 160000 / 20000

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] id_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic [1:0] brk_len_i = '0, dlm_len_i = '0;
  logic tx_o, busy_o, done_o;

  int total = 0, bad = 0;
  bit exp_bits[$];
  string exp_tag[$];
  int exp_len[$], exp_per[$];

  always #2.5 clk = ~clk;

  lin_hdr_gen #(.DIV_W(DIV_W), .CLK_HZ(160_000), .MAX_BPS(20_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_i(id_i), .div_i(div_i),
    .brk_len_i(brk_len_i), .dlm_len_i(dlm_len_i), .tx_o(tx_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: build expected header from the requirements, push, then strobe
  task automatic send_hdr(logic [5:0] id, logic [1:0] b, logic [1:0] d,
                          int dv, string tag);
    int p, n;
    logic [7:0] idb;
    p = (dv + 1 < MINP) ? MINP : dv + 1;   // R6, R7
    idb = {~^(id & 6'b111010), ^(id & 6'b010111), id};
    n = 0;
    for (int i = 0; i < 13 + b; i++) begin exp_bits.push_back(1'b0); exp_tag.push_back("R2"); n++; end
    for (int i = 0; i < 1 + d; i++)  begin exp_bits.push_back(1'b1); exp_tag.push_back("R3"); n++; end
    exp_bits.push_back(1'b0); exp_tag.push_back("R4"); n++;
    for (int i = 0; i < 8; i++) begin exp_bits.push_back(i[0] == 1'b0); exp_tag.push_back("R4"); n++; end
    exp_bits.push_back(1'b1); exp_tag.push_back("R4"); n++;
    exp_bits.push_back(1'b0); exp_tag.push_back("R5"); n++;
    for (int i = 0; i < 8; i++) begin exp_bits.push_back(idb[i]); exp_tag.push_back("R5"); n++; end
    exp_bits.push_back(1'b1); exp_tag.push_back("R5"); n++;
    exp_len.push_back(n);
    exp_per.push_back(p);
    id_i = id; brk_len_i = b; dlm_len_i = d; div_i = DIV_W'(dv);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, tag, busy_o, 1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  // monitor: compare each bit slot at mid-period, then the end timing
  task automatic run_frame();
    int n, p;
    bit b;
    string t;
    n = exp_len.pop_front();
    p = exp_per.pop_front();
    for (int s = 0; s < n; s++) begin
      b = exp_bits.pop_front();
      t = exp_tag.pop_front();
      for (int c = 0; c < p; c++) begin
        if (c == 0) chk(busy_o == 1'b1, "R8 busy during header", busy_o, 1);
        if (c == p / 2) chk(tx_o == b, t, tx_o, b);
        @(negedge clk);
      end
    end
    chk(busy_o == 1'b0, "R8 busy length", busy_o, 0);
    chk(done_o == 1'b1, "R9 done after last stop bit", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", done_o, 0);
  endtask

  initial begin
    wait (rst_n);
    @(negedge clk);
    forever begin
      if (busy_o) begin
        if (exp_len.size() == 0) begin
          chk(1'b0, "R10 unexpected header", 1, 0);
          @(negedge clk);
        end else run_frame();
      end else @(negedge clk);
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1 reset state",
        {tx_o, busy_o, done_o}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b1, "R1 idle line", tx_o, 1);

    // shortest break and delimiter, id all zero
    send_hdr(6'h00, 2'd0, 2'd0, 9, "R8 start accepted");
    wait_done();

    // longest fields; inputs change and start pulses mid-header
    send_hdr(6'h3F, 2'd3, 2'd3, 11, "R8 start accepted");
    repeat (60) @(negedge clk);
    div_i = '0; id_i = 6'h2A; brk_len_i = 2'd0; dlm_len_i = 2'd1;  // R6
    start_i = 1'b1;                                                 // R10
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0 && tx_o == 1'b1, "R10 no extra header", {busy_o, tx_o}, 2'b01);

    // requested period below the rate floor: R7
    send_hdr(6'h15, 2'd1, 2'd2, 2, "R7 clamped header start");
    wait_done();

    // back to back: start in the done cycle, R11
    send_hdr(6'h2A, 2'd2, 2'd1, 8, "R8 start accepted");
    wait_done();
    send_hdr(6'h11, 2'd0, 2'd0, 7, "R11 start in done cycle");
    wait_done();
    repeat (4) @(negedge clk);
    chk(exp_len.size() == 0, "R11 all headers seen", exp_len.size(), 0);
    chk(tx_o == 1'b1 && busy_o == 1'b0, "R1 idle after headers", {tx_o, busy_o}, 2'b10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule